// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the transmit side of a master-mode stereo audio serial link. A host pushes 16-bit words into it over a valid/ready stream. The block packs those words into channel slots and shifts them out MSB first on three lines: a bit clock, a word-select (or frame-sync) line and a serial data line. It generates the bit clock itself by dividing the system clock by a programmable even ratio.

Four framings are available: the Philips convention, MSB-justified, LSB-justified and a short-sync PCM mode. Samples can be 16, 24 or 32 bits wide and channels 16 or 32 slots long. Samples wider than 16 bits take two host words. Samples shorter than the channel are filled with zero bits. If the host falls behind, the block sends silence and raises a sticky underrun flag.

Stream rules: a word transfers on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` drops for as long as the single holding register is occupied. The holding register drains into a staging pair that keeps the words of the next channel. While the staging pair is full, the holding register also stays full, so back-pressure reaches the host. No word is dropped or repeated. The host may hold `s_valid` high for as long as it likes.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset `sck`, `ws`, `sd` and `underrun` are low and `s_ready` is high. The bit clock stays low until `enable` is high and the words of the first channel have arrived.
- R2: A word is taken when `s_valid` and `s_ready` are both high. `s_ready` is low while the holding register is occupied. Words go out in the order they were taken, and none is lost or repeated.
- R3: `cfg_dlen` selects the sample width: 0 = 16 bits, 1 = 24 bits, 2 or 3 = 32 bits. `cfg_clen` selects the channel length: 0 = 16 slots, 1 = 32 slots. A sample wider than 16 bits forces 32 slots. A 16-bit sample uses one word per channel. A wider sample uses two words, and the first word carries the upper 16 bits.
- R4: The most significant bit goes out first. In the two-channel framings `ws` is 0 for the left channel, `ws` is 1 for the right channel, and the left channel goes first. Receivers sample on the rising edge of `sck`.
- R5: A 16-bit sample in a 32-slot channel is followed by 16 zero bits. In LSB-justified framing the sample comes after 16 zero bits instead.
- R6: For 24-bit samples, the second word supplies bits [15:8] as the low data byte, and its bits [7:0] are ignored. The channel carries 24 data bits and then 8 zero bits. In LSB-justified framing it carries 8 zero bits and then the data.
- R7: When `cfg_std` = 0 (Philips), `ws` changes one slot before the MSB of the channel: the data is delayed by one slot relative to `ws`.
- R8: When `cfg_std` = 1 (MSB-justified), the MSB appears in the same slot in which `ws` changes. When `cfg_std` = 2 (LSB-justified), the last data bit falls in the last slot of the channel.
- R9: When `cfg_std` = 3 (PCM), a frame is one channel long. `ws` is a frame sync that is high for exactly one slot, the one immediately before the MSB.
- R10: If a channel starts without complete data, its slots carry zeros and `underrun` goes high. `underrun` stays high until `underrun_clr` is pulsed.
- R11: One `sck` period equals `cfg_ratio` system clocks. An odd ratio is rounded down, and a ratio below 2 acts as 2. `ws` and `sd` change only on falling edges of `sck`.
- R12: Dropping `enable` returns the block to idle, with `sck`, `ws` and `sd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the serializer; low forces idle |
| cfg_std | input | 2 | Framing: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| cfg_dlen | input | 2 | Sample width: 0 = 16, 1 = 24, 2/3 = 32 |
| cfg_clen | input | 1 | Channel length: 0 = 16 slots, 1 = 32 slots |
| cfg_ratio | input | DIV_W | System clocks per bit-clock period |
| s_valid | input | 1 | Host word valid |
| s_data | input | 16 | Host word |
| s_ready | output | 1 | Holding register free |
| underrun_clr | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |

## Verification
Faults inside this block show up as a changed bit stream on the wire, and most of them show up quickly. A slot counter or shift register that slips misplaces the MSB or `ws` within the first channel, which is 16 or 32 bit-clock periods. A wrong packing choice changes the data or padding pattern in the very first slots after the block starts. A word lost or repeated in the staging path appears as a wrong word in the next channel. The bench decodes the stream at each rising `sck` edge and compares every slot of both channels with a model built from the requirements. It also measures the bit-clock period.

// File: rtl/ats_pkg.sv
package ats_pkg;

  localparam int WORD_W = 16;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'd0,
    STD_MSBJ    = 2'd1,
    STD_LSBJ    = 2'd2,
    STD_PCM     = 2'd3
  } std_e;

  // Build a channel image left-aligned in 32 bits; bit 31 leaves first.
  function automatic logic [31:0] pack_chan(input std_e std, input logic [1:0] dl,
                                            input logic cl32,
                                            input logic [WORD_W-1:0] hi,
                                            input logic [WORD_W-1:0] lo);
    logic [31:0] img;
    logic        rjust;
    rjust = (std == STD_LSBJ);
    case (dl)
      2'd0:    img = (cl32 && rjust) ? {16'h0000, hi} : {hi, 16'h0000};
      2'd1:    img = rjust ? ({hi, lo & 16'hFF00} >> 8) : {hi, lo & 16'hFF00};
      default: img = {hi, lo};
    endcase
    return img;
  endfunction

endpackage

// File: rtl/ats_bclk_gen.sv
module ats_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             sck,
  output logic             fall_tick
);
  logic [DIV_W-1:0] half_raw;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] hc_q;
  logic             sck_q;
  logic             tick;

  always_comb begin
    half_raw = ratio >> 1;
    half     = (half_raw == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_raw;
    tick     = run && (hc_q == half - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      hc_q  <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      hc_q  <= '0;
      sck_q <= ~sck_q;
    end else begin
      hc_q  <= hc_q + 1'b1;
    end
  end

  assign sck       = sck_q;
  assign fall_tick = tick && sck_q;

  a_r11_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !sck_q);

endmodule

// File: rtl/ats_word_stage.sv
module ats_word_stage
  import ats_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  input  logic              need_two,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] hi,
  output logic [WORD_W-1:0] lo
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [1:0]        cnt_q;
  logic [WORD_W-1:0] hi_q, lo_q;
  logic              accept, move;

  always_comb begin
    full    = (cnt_q == (need_two ? 2'd2 : 2'd1));
    s_ready = !hold_vld_q;
    accept  = s_valid && s_ready;
    move    = hold_vld_q && !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (accept) begin
      hold_q     <= s_data;
      hold_vld_q <= 1'b1;
    end else if (move) begin
      hold_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (take) begin
      cnt_q <= 2'd0;
    end else if (move) begin
      cnt_q <= cnt_q + 2'd1;
      if (cnt_q == 2'd0) hi_q <= hold_q;
      else               lo_q <= hold_q;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r2_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt_q != 2'd0));

endmodule

// File: rtl/ats_frame_shift.sv
module ats_frame_shift
  import ats_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  std_e              std,
  input  logic [1:0]        dl,
  input  logic              cl,
  input  logic              fall_tick,
  input  logic              st_full,
  input  logic [WORD_W-1:0] st_hi,
  input  logic [WORD_W-1:0] st_lo,
  input  logic              underrun_clr,
  output logic              take,
  output logic              run,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);
  logic              run_q, c_q, last_q, ws_q, sd_q, ur_q;
  logic [SLOT_W-1:0] j_q, nj, last_j;
  logic [31:0]       sh_q, vec;
  logic              nc, cl32, delayed, pcm, go, adv, chan_start, bit_now;

  always_comb begin
    cl32       = cl || (dl != 2'd0);
    last_j     = cl32 ? 5'd31 : 5'd15;
    pcm        = (std == STD_PCM);
    delayed    = (std == STD_PHILIPS) || pcm;
    go         = enable && !run_q && st_full;
    adv        = enable && run_q && fall_tick;
    chan_start = go || (adv && (j_q == last_j));
    take       = chan_start && st_full;
    vec        = take ? pack_chan(std, dl, cl32, st_hi, st_lo) : 32'h0;
    bit_now    = chan_start ? vec[31] : sh_q[31];
    if (go) begin
      nj = '0;
      nc = 1'b0;
    end else if (j_q == last_j) begin
      nj = '0;
      nc = pcm ? 1'b0 : ~c_q;
    end else begin
      nj = j_q + 5'd1;
      nc = c_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; j_q <= '0; c_q <= 1'b0; sh_q <= '0;
      last_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else if (!enable) begin
      run_q <= 1'b0; j_q <= '0; c_q <= 1'b0; sh_q <= '0;
      last_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else if (go || adv) begin
      run_q  <= 1'b1;
      j_q    <= nj;
      c_q    <= nc;
      sh_q   <= chan_start ? (vec << 1) : (sh_q << 1);
      last_q <= bit_now;
      sd_q   <= delayed ? last_q : bit_now;
      ws_q   <= pcm ? (nj == '0) : nc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ur_q <= 1'b0;
    else if (adv && chan_start && !st_full) ur_q <= 1'b1;
    else if (underrun_clr)                 ur_q <= 1'b0;
  end

  assign run      = run_q;
  assign ws       = ws_q;
  assign sd       = sd_q;
  assign underrun = ur_q;

  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(fall_tick)) |-> ($stable(ws_q) && $stable(sd_q)));

  a_r9_sync_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm && run_q && $past(run_q) && $past(fall_tick) && $past(ws_q)) |-> !ws_q);

  a_r10_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ur_q) && !$past(underrun_clr)) |-> ur_q);

  a_r4_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !pcm) |=> !ws_q);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       cfg_std,
  input  logic [1:0]       cfg_dlen,
  input  logic             cfg_clen,
  input  logic [DIV_W-1:0] cfg_ratio,
  input  logic             s_valid,
  input  logic [15:0]      s_data,
  output logic             s_ready,
  input  logic             underrun_clr,
  output logic             underrun,
  output logic             sck,
  output logic             ws,
  output logic             sd
);
  import ats_pkg::*;

  std_e        std_sel;
  logic        take, st_full, run, fall_tick;
  logic [15:0] st_hi, st_lo;

  assign std_sel = std_e'(cfg_std);

  ats_word_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .s_ready  (s_ready),
    .need_two (cfg_dlen != 2'd0),
    .take     (take),
    .full     (st_full),
    .hi       (st_hi),
    .lo       (st_lo)
  );

  ats_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ratio     (cfg_ratio),
    .sck       (sck),
    .fall_tick (fall_tick)
  );

  ats_frame_shift u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .std          (std_sel),
    .dl           (cfg_dlen),
    .cl           (cfg_clen),
    .fall_tick    (fall_tick),
    .st_full      (st_full),
    .st_hi        (st_hi),
    .st_lo        (st_lo),
    .underrun_clr (underrun_clr),
    .take         (take),
    .run          (run),
    .ws           (ws),
    .sd           (sd),
    .underrun     (underrun)
  );

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0]  std;
    logic [1:0]  dl;
    logic        cl;
    logic [7:0]  ratio;
    logic [63:0] w;
  } vec_t;

  localparam vec_t VECS [0:NVEC-1] = '{
    '{2'd0, 2'd0, 1'b0, 8'd4, 64'hA5C3_1E0F_0000_0000},
    '{2'd1, 2'd0, 1'b1, 8'd2, 64'hF00D_8001_0000_0000},
    '{2'd2, 2'd0, 1'b1, 8'd6, 64'hC0DE_7E81_0000_0000},
    '{2'd0, 2'd1, 1'b1, 8'd4, 64'h8123_45FF_9ABC_DE77},
    '{2'd2, 2'd1, 1'b1, 8'd2, 64'hB1E5_C3AA_0F0F_F055},
    '{2'd1, 2'd2, 1'b1, 8'd4, 64'hDEAD_BEEF_1357_9BDF},
    '{2'd3, 2'd0, 1'b0, 8'd4, 64'hE001_4C4C_0000_0000},
    '{2'd3, 2'd2, 1'b1, 8'd2, 64'h8642_0FED_5A5A_A5A5},
    '{2'd1, 2'd1, 1'b0, 8'd5, 64'hFACE_1234_89AB_CDEF},
    '{2'd2, 2'd0, 1'b0, 8'd1, 64'h9F01_60FE_0000_0000}
  };

  logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] cfg_std = 2'd0, cfg_dlen = 2'd0;
  logic       cfg_clen = 1'b0;
  logic [7:0] cfg_ratio = 8'd2;
  logic       s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic       s_ready, underrun_clr = 1'b0, underrun, sck, ws, sd;

  int errors = 0, checks = 0;
  int unsigned cyc = 0;
  logic ws_cap [0:127];
  logic sd_cap [0:127];
  int unsigned t_r0, t_r1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aud_ser_tx #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_std(cfg_std), .cfg_dlen(cfg_dlen),
    .cfg_clen(cfg_clen), .cfg_ratio(cfg_ratio), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .underrun_clr(underrun_clr), .underrun(underrun),
    .sck(sck), .ws(ws), .sd(sd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; s_valid = 1'b0; underrun_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic capture(input int n);
    int got;
    logic prev;
    got = 0;
    prev = sck;
    while (got < n) begin
      @(negedge clk);
      if (sck && !prev) begin
        ws_cap[got] = ws; sd_cap[got] = sd;
        if (got == 0) t_r0 = cyc;
        if (got == 1) t_r1 = cyc;
        got++;
      end
      prev = sck;
    end
  endtask

  function automatic int chan_len(vec_t v);
    return (v.cl || v.dl != 2'd0) ? 32 : 16;
  endfunction

  function automatic int dbits(vec_t v);
    return (v.dl == 2'd0) ? 16 : (v.dl == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic [15:0] word_of(vec_t v, int i);
    return v.w[63-16*i -: 16];
  endfunction

  function automatic logic chan_bit(vec_t v, int ch, int j);
    int wpc, n, cl, pad;
    logic [15:0] a, b;
    logic [31:0] d;
    if (ch > 1) return 1'b0;            // no data supplied: silence
    wpc = (v.dl == 2'd0) ? 1 : 2;
    a = word_of(v, ch*wpc);
    b = (wpc == 2) ? word_of(v, ch*wpc+1) : 16'h0;
    if (v.dl == 2'd0)      d = {16'h0, a};
    else if (v.dl == 2'd1) d = {8'h0, a, b[15:8]};   // R6: low byte dropped
    else                   d = {a, b};
    n = dbits(v); cl = chan_len(v);
    if (v.std == 2'd2) begin
      pad = cl - n;
      if (j < pad) return 1'b0;
      return d[n-1-(j-pad)];
    end
    if (j < n) return d[n-1-j];
    return 1'b0;
  endfunction

  function automatic logic exp_sd(vec_t v, int s);
    int cl, t;
    cl = chan_len(v); t = s;
    if (v.std == 2'd0 || v.std == 2'd3) begin
      if (s == 0) return 1'b0;
      t = s - 1;
    end
    return chan_bit(v, t / cl, t % cl);
  endfunction

  function automatic logic exp_ws(vec_t v, int s);
    int cl;
    cl = chan_len(v);
    if (v.std == 2'd3) return ((s % cl) == 0);
    return ((s / cl) % 2) == 1;
  endfunction

  task automatic push_all(vec_t v);
    int nw;
    nw = (v.dl == 2'd0) ? 2 : 4;
    for (int i = 0; i < nw; i++) push(word_of(v, i));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
    chk(ws == 1'b0, "R1", "ws after reset", ws, 0);
    chk(sd == 1'b0, "R1", "sd after reset", sd, 0);
    chk(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
    chk(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);

    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      int n, mism, first, er;
      string tag;
      v = VECS[k];
      do_reset();
      cfg_std = v.std; cfg_dlen = v.dl; cfg_clen = v.cl; cfg_ratio = v.ratio;
      enable = 1'b1;
      n = 2 * chan_len(v) + 1;
      fork
        push_all(v);
        capture(n);
      join
      mism = 0; first = -1;
      for (int s = 0; s < n; s++) begin
        if (ws_cap[s] !== exp_ws(v, s) || sd_cap[s] !== exp_sd(v, s)) begin
          mism++;
          if (first < 0) first = s;
        end
      end
      case (v.std)
        2'd0:    tag = "R4 R7";
        2'd1:    tag = "R4 R8";
        2'd2:    tag = "R8 R5";
        default: tag = "R9";
      endcase
      if (v.dl == 2'd1) tag = {tag, " R6"};
      if (v.dl == 2'd0 && v.cl) tag = {tag, " R5"};
      if (v.dl != 2'd0 && !v.cl) tag = {tag, " R3"};
      chk(mism == 0, tag, $sformatf("vector %0d slot mismatches (first slot %0d)", k, first),
          mism, 0);
      er = (v.ratio < 8'd2) ? 2 : int'(v.ratio & 8'hFE);
      chk((t_r1 - t_r0) == er, "R11", $sformatf("vector %0d sck period", k),
          t_r1 - t_r0, er);
      chk(underrun == 1'b1, "R10", $sformatf("vector %0d underrun after data ran out", k),
          underrun, 1);
    end

    // Back-pressure and ordering (MSB-justified, 16 in 16)
    do_reset();
    cfg_std = 2'd1; cfg_dlen = 2'd0; cfg_clen = 1'b0; cfg_ratio = 8'd2;
    push(16'hBEEF);
    push(16'h1234);
    repeat (2) @(negedge clk);
    chk(s_ready == 1'b0, "R2", "s_ready with holding and staging full", s_ready, 0);
    begin
      int toggles;
      toggles = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (sck) toggles++;
      end
      chk(toggles == 0, "R1", "sck idle while enable low", toggles, 0);
    end
    enable = 1'b1;
    fork
      push(16'h5A5A);
      capture(48);
    join
    for (int c = 0; c < 3; c++) begin
      logic [15:0] got, exp;
      for (int b = 0; b < 16; b++) got[15-b] = sd_cap[16*c+b];
      exp = (c == 0) ? 16'hBEEF : (c == 1) ? 16'h1234 : 16'h5A5A;
      chk(got == exp, "R2", $sformatf("word %0d order", c), got, exp);
    end
    chk(ws_cap[16] == 1'b1 && ws_cap[0] == 1'b0, "R4", "left then right select",
        {ws_cap[0], ws_cap[16]}, 2'b01);
    repeat (6) @(negedge clk);
    chk(underrun == 1'b1, "R10", "underrun when stage empty", underrun, 1);
    capture(4);
    chk({sd_cap[0], sd_cap[1], sd_cap[2], sd_cap[3]} == 4'h0, "R10", "silence on underrun",
        {sd_cap[0], sd_cap[1], sd_cap[2], sd_cap[3]}, 0);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk({sck, ws, sd} == 3'b000, "R12", "lines idle after disable", {sck, ws, sd}, 0);
    chk(underrun == 1'b1, "R10", "underrun held without clear", underrun, 1);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    chk(underrun == 1'b0, "R10", "underrun cleared", underrun, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule